// File: doc/BRIEF.md
# Next Fetch Line Predictor

This block keeps a small table of guesses about which instruction-cache line the front end should read next. The cache is organised in lines of eight instructions, and each line is treated as two four-word halves (words 0-3 and words 4-7). Every half owns one table entry that holds a line index, not a full address. After reset, both entries of line `n` point to line `n+1`, which is the sequential guess, and the index wraps at the top of the table.

Each cycle the fetch unit describes the group it just fetched: the line, the first word, how many words (1 to 4, contiguous, possibly straddling the half boundary) and, optionally, the word position of the delay slot of a control transfer that is predicted taken. The block picks one entry and loads it into the prediction register, which names the only line the next fetch may read. Later the pipeline reports the line that was really needed. If that differs from the prediction, the entry that produced the guess is overwritten with the correct index, the prediction register takes the correct index at once, and fetch is held for a fixed two cycles. While the hold is active, group reports and resolve reports are both ignored.

Top module: `next_line_pred`

## Requirements
- R1: After reset `pred_line` is 0, `fetch_hold` is low, and both entries of line n hold (n+1) modulo 2^LINE_W.
- R2: A group accepted with no usable delay-slot report loads `pred_line`, one cycle later, from the entry of the half holding `grp_start` (bit 2 of the word position: 0 selects words 0-3, 1 selects words 4-7).
- R3: A group accepted with `grp_ds_valid` high and `grp_ds_word` inside the group loads `pred_line` from the entry of the half holding `grp_ds_word` (again its bit 2).
- R4: A delay-slot position outside the words `grp_start` to `grp_start + grp_count - 1` is ignored, and selection falls back to R2.
- R5: A resolve whose `rslv_line` equals `pred_line` raises no hold and changes neither the table nor the prediction.
- R6: A resolve whose `rslv_line` differs from `pred_line` sets `pred_line` to `rslv_line` in the next cycle, writes `rslv_line` into the entry that produced the prediction, and raises `fetch_hold` for exactly STALL_CYC (2) cycles.
- R7: While `fetch_hold` is high, group and resolve inputs have no effect and `pred_line` holds.
- R8: When a mispredicting resolve and a group report arrive in the same cycle, the repair is made and the group is dropped.
- R9: Repeated repairs of one entry leave the latest index in it.
- R10: Line indices wrap: line 2^LINE_W-1 predicts line 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A fetched group is described this cycle |
| grp_line | input | LINE_W | Line index of the fetched group |
| grp_start | input | 3 | Word position of the group's first instruction |
| grp_count | input | 3 | Number of words in the group, 1 to 4 |
| grp_ds_valid | input | 1 | The group holds a taken-transfer delay slot |
| grp_ds_word | input | 3 | Word position of that delay slot |
| rslv_valid | input | 1 | The actual next line is reported this cycle |
| rslv_line | input | LINE_W | Actual next line index |
| pred_line | output | LINE_W | Current predicted next line |
| fetch_hold | output | 1 | Fetch is held for repair |

## Verification
A group report and a resolve can land in the same cycle, and the outcome depends on whether the resolve matches the held prediction. The bench drives both together twice: once with a matching resolve, where the group must still load the prediction from its chosen entry, and once with a mismatch, where the repaired index must appear, the hold must start and the group must leave no trace. A reference copy of the table in the bench tracks every repair, so a later group reading the repaired entry exposes a write to the wrong half or a write that never happened.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

  localparam int LINE_WORDS = 8;
  localparam int WORD_W     = $clog2(LINE_WORDS);
  localparam int CNT_W      = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  count_t;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // the top word-position bit tells the two halves apart
  function automatic half_e half_of(input word_t w);
    return half_e'(w[WORD_W-1]);
  endfunction

endpackage

// File: rtl/nlp_half_pick.sv
module nlp_half_pick
  import nlp_pkg::*;
(
  input  word_t  start,
  input  count_t count,
  input  logic   ds_valid,
  input  word_t  ds_word,
  output half_e  half
);

  logic [WORD_W:0] lo_pos;
  logic [WORD_W:0] end_pos;
  logic [WORD_W:0] ds_pos;
  logic            ds_inside;

  always_comb begin
    lo_pos    = {1'b0, start};
    end_pos   = lo_pos + (WORD_W+1)'(count);
    ds_pos    = {1'b0, ds_word};
    ds_inside = ds_valid && (ds_pos >= lo_pos) && (ds_pos < end_pos);
    half      = ds_inside ? half_of(ds_word) : half_of(start);
  end

endmodule

// File: rtl/nlp_slot_table.sv
module nlp_slot_table #(
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W:0]   rd_addr,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [LINE_W:0]   wr_addr,
  input  logic [LINE_W-1:0] wr_data
);

  localparam int DEPTH = 2 ** (LINE_W + 1);

  logic [DEPTH-1:0][LINE_W-1:0] slots;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    // entries 2n and 2n+1 belong to line n; sequential guess is n+1
    localparam logic [LINE_W-1:0] SEQ_IDX = LINE_W'((g >> 1) + 1);

    logic              hit;
    logic [LINE_W-1:0] q;

    always_comb hit = wr_en && (wr_addr == (LINE_W+1)'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= SEQ_IDX;
      end else if (hit) begin
        q <= wr_data;
      end
    end

    assign slots[g] = q;
  end

  assign rd_data = slots[rd_addr];

endmodule

// File: rtl/nlp_stall_ctr.sv
module nlp_stall_ctr #(
  parameter int STALL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CW = $clog2(STALL_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = load || busy;
    cnt_d  = load ? CW'(STALL_CYC) : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/next_line_pred.sv
module next_line_pred
  import nlp_pkg::*;
#(
  parameter int LINE_W    = 5,
  parameter int STALL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_valid,
  input  logic [LINE_W-1:0] grp_line,
  input  logic [2:0]        grp_start,
  input  logic [2:0]        grp_count,
  input  logic              grp_ds_valid,
  input  logic [2:0]        grp_ds_word,
  input  logic              rslv_valid,
  input  logic [LINE_W-1:0] rslv_line,
  output logic [LINE_W-1:0] pred_line,
  output logic              fetch_hold
);

  localparam int ADDR_W = LINE_W + 1;

  half_e             pick_half;
  logic [ADDR_W-1:0] rd_addr;
  logic [LINE_W-1:0] rd_data;
  logic              miss;
  logic              take_grp;
  logic              busy;

  logic [LINE_W-1:0] pred_q, pred_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic              upd_en;

  nlp_half_pick u_pick (
    .start    (word_t'(grp_start)),
    .count    (count_t'(grp_count)),
    .ds_valid (grp_ds_valid),
    .ds_word  (word_t'(grp_ds_word)),
    .half     (pick_half)
  );

  nlp_slot_table #(.LINE_W(LINE_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (miss),
    .wr_addr (src_q),
    .wr_data (rslv_line)
  );

  nlp_stall_ctr #(.STALL_CYC(STALL_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (miss),
    .busy  (busy)
  );

  always_comb begin
    rd_addr  = {grp_line, pick_half};
    miss     = rslv_valid && !busy && (rslv_line != pred_q);
    take_grp = grp_valid && !busy && !miss;
    upd_en   = miss || take_grp;
    pred_d   = miss ? rslv_line : rd_data;
    src_d    = take_grp ? rd_addr : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      src_q  <= '0;
    end else if (upd_en) begin
      pred_q <= pred_d;
      src_q  <= src_d;
    end
  end

  assign pred_line  = pred_q;
  assign fetch_hold = busy;

endmodule

// File: rtl/next_line_pred_chk.sv
module next_line_pred_chk #(
  parameter int LINE_W    = 5,
  parameter int STALL_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grp_valid,
  input logic              rslv_valid,
  input logic [LINE_W-1:0] rslv_line,
  input logic [LINE_W-1:0] pred_line,
  input logic              fetch_hold
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (fetch_hold) begin
      run_q <= run_q + 8'd1;
    end else begin
      run_q <= '0;
    end
  end

  AST_MISS_REPAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    rslv_valid && !fetch_hold && (rslv_line != pred_line)
      |=> fetch_hold && (pred_line == $past(rslv_line))); // R6

  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_hold) |-> (run_q == 8'(STALL_CYC))); // R6

  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_hold) |-> $past(rslv_valid)); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fetch_hold) |-> $stable(pred_line)); // R7

  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rslv_valid && !fetch_hold && (rslv_line == pred_line) && !grp_valid
      |=> !fetch_hold && $stable(pred_line)); // R5

endmodule

bind next_line_pred next_line_pred_chk #(
  .LINE_W    (LINE_W),
  .STALL_CYC (STALL_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grp_valid  (grp_valid),
  .rslv_valid (rslv_valid),
  .rslv_line  (rslv_line),
  .pred_line  (pred_line),
  .fetch_hold (fetch_hold)
);

// File: tb/sim_next_line_pred.sv
module sim_next_line_pred;

  localparam int W     = 5;
  localparam int NSLOT = 2 ** (W + 1);
  localparam int HOLD  = 2;

  typedef struct packed {
    logic [3:0]   req;
    logic         gv;
    logic [W-1:0] line;
    logic [2:0]   st;
    logic [2:0]   cnt;
    logic         dv;
    logic [2:0]   dw;
    logic         rv;
    logic [W-1:0] rl;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 5'd3,  3'd0, 3'd4, 1'b0, 3'd0, 1'b0, 5'd0},  // R2 plain group
    '{4'd6,  1'b0, 5'd0,  3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 5'd9},  // R6 mismatch
    '{4'd7,  1'b1, 5'd10, 3'd0, 3'd1, 1'b0, 3'd0, 1'b1, 5'd0},  // R7 ignored in hold
    '{4'd7,  1'b1, 5'd12, 3'd4, 3'd2, 1'b0, 3'd0, 1'b1, 5'd1},  // R7 ignored in hold
    '{4'd2,  1'b1, 5'd3,  3'd2, 3'd4, 1'b0, 3'd0, 1'b0, 5'd0},  // R2 straddle, no slot
    '{4'd3,  1'b1, 5'd3,  3'd2, 3'd4, 1'b1, 3'd5, 1'b0, 5'd0},  // R3 straddle, slot high
    '{4'd4,  1'b1, 5'd3,  3'd1, 3'd2, 1'b1, 3'd6, 1'b1, 5'd4},  // R4 + R5 match
    '{4'd8,  1'b1, 5'd8,  3'd0, 3'd4, 1'b0, 3'd0, 1'b1, 5'd20}, // R8 repair wins
    '{4'd7,  1'b0, 5'd0,  3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 5'd0},
    '{4'd7,  1'b0, 5'd0,  3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 5'd0},
    '{4'd6,  1'b1, 5'd3,  3'd0, 3'd1, 1'b0, 3'd0, 1'b0, 5'd0},  // R6 entry rewritten
    '{4'd9,  1'b0, 5'd0,  3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 5'd21}, // R9 second repair
    '{4'd7,  1'b0, 5'd0,  3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 5'd0},
    '{4'd7,  1'b0, 5'd0,  3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 5'd0},
    '{4'd9,  1'b1, 5'd3,  3'd3, 3'd1, 1'b0, 3'd0, 1'b0, 5'd0},  // R9 latest kept
    '{4'd10, 1'b1, 5'd31, 3'd4, 3'd4, 1'b0, 3'd0, 1'b0, 5'd0},  // R10 wrap
    '{4'd3,  1'b1, 5'd31, 3'd7, 3'd1, 1'b1, 3'd7, 1'b0, 5'd0},  // R3 last word
    '{4'd3,  1'b1, 5'd0,  3'd4, 3'd3, 1'b1, 3'd5, 1'b0, 5'd0}   // R3 upper half
  };

  logic         clk;
  logic         rst_n;
  logic         grp_valid;
  logic [W-1:0] grp_line;
  logic [2:0]   grp_start;
  logic [2:0]   grp_count;
  logic         grp_ds_valid;
  logic [2:0]   grp_ds_word;
  logic         rslv_valid;
  logic [W-1:0] rslv_line;
  logic [W-1:0] pred_line;
  logic         fetch_hold;

  int n_checks;
  int n_fails;
  bit done;

  logic [W-1:0] m_tbl [NSLOT];
  logic [W-1:0] m_pred;
  logic [W:0]   m_src;
  int           m_cnt;

  next_line_pred #(.LINE_W(W), .STALL_CYC(HOLD)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_valid    (grp_valid),
    .grp_line     (grp_line),
    .grp_start    (grp_start),
    .grp_count    (grp_count),
    .grp_ds_valid (grp_ds_valid),
    .grp_ds_word  (grp_ds_word),
    .rslv_valid   (rslv_valid),
    .rslv_line    (rslv_line),
    .pred_line    (pred_line),
    .fetch_hold   (fetch_hold)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic model_reset();
    for (int l = 0; l < NSLOT / 2; l++) begin
      m_tbl[2*l]   = W'(l + 1);
      m_tbl[2*l+1] = W'(l + 1);
    end
    m_pred = '0;
    m_src  = '0;
    m_cnt  = 0;
  endtask

  task automatic model_step(input vec_t v);
    bit held;
    bit miss;
    bit hi;
    held = (m_cnt != 0);
    miss = v.rv && !held && (v.rl != m_pred);
    if (miss) begin
      m_tbl[m_src] = v.rl;
      m_pred       = v.rl;
      m_cnt        = HOLD;
    end else begin
      if (held) m_cnt = m_cnt - 1;
      if (!held && v.gv) begin
        if (v.dv && int'(v.dw) >= int'(v.st) && int'(v.dw) < int'(v.st) + int'(v.cnt))
          hi = v.dw[2];
        else
          hi = v.st[2];
        m_src  = {v.line, hi};
        m_pred = m_tbl[m_src];
      end
    end
  endtask

  task automatic check(input string req, input logic [W-1:0] exp_pred, input bit exp_hold);
    n_checks++;
    if (pred_line !== exp_pred || fetch_hold !== exp_hold) begin
      n_fails++;
      $display("FAIL %s: pred_line=%0d fetch_hold=%0b, expected pred_line=%0d fetch_hold=%0b",
               req, pred_line, fetch_hold, exp_pred, exp_hold);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    grp_valid    = v.gv;
    grp_line     = v.line;
    grp_start    = v.st;
    grp_count    = v.cnt;
    grp_ds_valid = v.dv;
    grp_ds_word  = v.dw;
    rslv_valid   = v.rv;
    rslv_line    = v.rl;
    model_step(v);
    @(posedge clk);
    #1;
    check($sformatf("R%0d", v.req), m_pred, m_cnt != 0);
  endtask

  function automatic vec_t mk(input logic [3:0] rq, input bit gv, input int line,
                              input int st, input int cnt, input bit dv, input int dw,
                              input bit rv, input int rl);
    vec_t v;
    v.req = rq; v.gv = gv; v.line = W'(line); v.st = 3'(st); v.cnt = 3'(cnt);
    v.dv = dv; v.dw = 3'(dw); v.rv = rv; v.rl = W'(rl);
    return v;
  endfunction

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0;
    grp_valid = 1'b0; grp_line = '0; grp_start = '0; grp_count = '0;
    grp_ds_valid = 1'b0; grp_ds_word = '0; rslv_valid = 1'b0; rslv_line = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);        // R1 reset state while held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0);        // R1 reset state after release

    for (int i = 0; i < NV; i++) drive(VECS[i]);

    // R1: a second reset restores the sequential guesses
    apply_reset();
    check("R1", '0, 1'b0);
    drive(mk(4'd1, 1'b1, 3, 0, 4, 1'b0, 0, 1'b0, 0));
    check("R1", W'(4), 1'b0);

    // R6: hold lasts exactly two cycles, checked cycle by cycle
    drive(mk(4'd6, 1'b0, 0, 0, 0, 1'b0, 0, 1'b1, 17));
    check("R6", W'(17), 1'b1);
    drive(mk(4'd7, 1'b0, 0, 0, 0, 1'b0, 0, 1'b0, 0));
    check("R6", W'(17), 1'b1);
    drive(mk(4'd7, 1'b0, 0, 0, 0, 1'b0, 0, 1'b0, 0));
    check("R6", W'(17), 1'b0);

    // R5 with a group in the same cycle: the group is still taken
    drive(mk(4'd5, 1'b1, 6, 5, 2, 1'b0, 0, 1'b1, 17));
    check("R5", W'(7), 1'b0);

    // R4: delay slot ahead of the group start is ignored
    drive(mk(4'd4, 1'b1, 3, 5, 3, 1'b1, 2, 1'b0, 0));
    check("R4", W'(4), 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

endmodule